// File: doc/BRIEF.md
# Multi-Block Coefficient Run Sequencer

This block drives one triggered coding run over a configurable number of 8x8 coefficient blocks. A start pulse latches the run setup: the block count, a per-block luminance mask, the coefficient source address and four Huffman table base offsets. The block then walks through every block of the run, 64 coefficient positions per block. Each cycle of the run it issues one coefficient read address. Alongside that address it gives the coding datapath the current block index, the block's luma/chroma flag and the DC and AC table bases for that block.

Coefficients are 16-bit words and are read from consecutive byte addresses. The address does not restart at a block boundary. When the last coefficient of the last block has been issued, busy falls and done pulses for one cycle. Huffman lookup, quantization and bit packing are handled by other logic.

Top module: `coef_run_seq`

## Requirements
- R1: A start that is accepted while idle, with a block count N of 1 to 6, raises busy and rd_valid in the cycle after start. Both stay high for exactly 64*N cycles, with one read issued per cycle.
- R2: The first read address equals cfg_src_base. Each later read adds 2 bytes, one 16-bit word. The sequence runs on without a break from one block into the next.
- R3: cfg_nblk is a 3-bit count. The value 7 is clamped to 6, so the run covers 6 blocks.
- R4: A start with N equal to 0 pulses done in the cycle after start. It issues no read, and busy stays low.
- R5: Bit i of cfg_luma marks block i of the run as luminance, where block 0 is the first block of the run. A luminance block gets the DC and AC luminance bases, and blk_is_luma is 1. Any other block gets the chrominance bases, and blk_is_luma is 0.
- R6: The dc_base and ac_base outputs always have bits [1:0] equal to 0, whatever the configured offsets contain.
- R7: Over the 64 cycles of one block, blk_idx, blk_is_luma, dc_base and ac_base do not change. Over the same cycles coef_idx counts from 0 to 63. blk_idx counts from 0 to N-1 across the run.
- R8: A start pulse while busy is ignored. The run in progress neither restarts nor changes length.
- R9: All configuration inputs are captured when a start is accepted. Changing them during a run has no effect on that run.
- R10: Done is a single-cycle pulse in the cycle after the last read. In that cycle busy and rd_valid are already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run trigger, one cycle |
| cfg_nblk | input | 3 | Blocks per run (0..6, 7 clamps to 6) |
| cfg_luma | input | 6 | Per-block luminance mask |
| cfg_src_base | input | 32 | Byte address of the first coefficient |
| cfg_dc_luma | input | 16 | DC luminance table offset |
| cfg_dc_chroma | input | 16 | DC chrominance table offset |
| cfg_ac_luma | input | 16 | AC luminance table offset |
| cfg_ac_chroma | input | 16 | AC chrominance table offset |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_valid | output | 1 | rd_addr carries a read this cycle |
| rd_addr | output | 32 | Coefficient read byte address |
| blk_idx | output | 3 | Block index within the run |
| coef_idx | output | 6 | Coefficient position within the block |
| blk_is_luma | output | 1 | Current block is luminance |
| dc_base | output | 16 | Selected DC table base, word aligned |
| ac_base | output | 16 | Selected AC table base, word aligned |

## Verification
The hardest cases to reach from the ports are a start pulse that lands in the middle of a run and a configuration that changes after it has been captured. Both affect the design only through state it holds internally. To reach them, every run of the sweep drives a new setup on all configuration inputs right after the accepted start, then pulses start again at element 5. Expected reads are recomputed from the original setup, so any re-capture or restart appears as a wrong address, index or base. The sweep covers every N from 0 to 7 against four luminance masks, with table offsets whose low bits are set.

// File: rtl/coef_run_seq.sv
module coef_run_seq #(
  parameter int ADDR_W       = 32,
  parameter int TBL_W        = 16,
  parameter int MAX_BLK      = 6,
  parameter int NB_W         = 3,
  parameter int COEF_PER_BLK = 64,
  parameter int ELEM_BYTES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NB_W-1:0]   cfg_nblk,
  input  logic [MAX_BLK-1:0] cfg_luma,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [TBL_W-1:0]  cfg_dc_luma,
  input  logic [TBL_W-1:0]  cfg_dc_chroma,
  input  logic [TBL_W-1:0]  cfg_ac_luma,
  input  logic [TBL_W-1:0]  cfg_ac_chroma,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [NB_W-1:0]   blk_idx,
  output logic [$clog2(COEF_PER_BLK)-1:0] coef_idx,
  output logic              blk_is_luma,
  output logic [TBL_W-1:0]  dc_base,
  output logic [TBL_W-1:0]  ac_base
);
  localparam int CO_W   = $clog2(COEF_PER_BLK);
  localparam int LV_PAD = 2 ** NB_W;
  localparam logic [NB_W-1:0] MAX_N    = NB_W'(MAX_BLK);
  localparam logic [CO_W-1:0] LAST_CO  = CO_W'(COEF_PER_BLK - 1);
  localparam logic [TBL_W-1:0] ALIGN_M = ~TBL_W'(3);

  logic              busy_q, done_q;
  logic [NB_W-1:0]   blk_q, n_q;
  logic [CO_W-1:0]   coef_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MAX_BLK-1:0] luma_q;
  logic [TBL_W-1:0]  dcl_q, dcc_q, acl_q, acc_q;

  logic [NB_W-1:0]   n_clamp;
  logic [LV_PAD-1:0] luma_pad;
  logic              accept, blk_end, last_elem;

  assign n_clamp   = (cfg_nblk > MAX_N) ? MAX_N : cfg_nblk;
  assign accept    = start && !busy_q;
  assign blk_end   = busy_q && (coef_q == LAST_CO);
  assign last_elem = blk_end && (blk_q == n_q - NB_W'(1));
  assign luma_pad  = LV_PAD'(luma_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      blk_q  <= '0;
      n_q    <= '0;
      coef_q <= '0;
      addr_q <= '0;
      luma_q <= '0;
      dcl_q  <= '0;
      dcc_q  <= '0;
      acl_q  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        n_q    <= n_clamp;
        luma_q <= cfg_luma;
        dcl_q  <= cfg_dc_luma;
        dcc_q  <= cfg_dc_chroma;
        acl_q  <= cfg_ac_luma;
        acc_q  <= cfg_ac_chroma;
        addr_q <= cfg_src_base;
        blk_q  <= '0;
        coef_q <= '0;
        if (n_clamp == '0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end else if (busy_q) begin
        addr_q <= addr_q + ADDR_W'(ELEM_BYTES);
        coef_q <= coef_q + CO_W'(1);
        if (blk_end) blk_q <= blk_q + NB_W'(1);
        if (last_elem) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign rd_valid    = busy_q;
  assign done        = done_q;
  assign rd_addr     = addr_q;
  assign blk_idx     = blk_q;
  assign coef_idx    = coef_q;
  assign blk_is_luma = luma_pad[blk_q];
  assign dc_base     = (blk_is_luma ? dcl_q : dcc_q) & ALIGN_M;
  assign ac_base     = (blk_is_luma ? acl_q : acc_q) & ALIGN_M;

  assert_addr_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> rd_addr == $past(rd_addr) + ADDR_W'(ELEM_BYTES));

  assert_blk_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blk_idx < MAX_N);

  assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dc_base[1:0] == 2'b00 && ac_base[1:0] == 2'b00);

  assert_block_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && coef_idx != '0 |->
      $stable(blk_idx) && $stable(dc_base) && $stable(ac_base) && $stable(blk_is_luma));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && coef_idx != LAST_CO |=> busy && coef_idx == $past(coef_idx) + CO_W'(1));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_valid);
endmodule

// File: tb/coef_run_seq_tb.sv
`timescale 1ns/1ps
module coef_run_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  cfg_nblk = '0;
  logic [5:0]  cfg_luma = '0;
  logic [31:0] cfg_src_base = '0;
  logic [15:0] cfg_dc_luma = '0, cfg_dc_chroma = '0, cfg_ac_luma = '0, cfg_ac_chroma = '0;
  logic busy, done, rd_valid, blk_is_luma;
  logic [31:0] rd_addr;
  logic [2:0]  blk_idx;
  logic [5:0]  coef_idx;
  logic [15:0] dc_base, ac_base;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  coef_run_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_nblk(cfg_nblk), .cfg_luma(cfg_luma),
    .cfg_src_base(cfg_src_base), .cfg_dc_luma(cfg_dc_luma), .cfg_dc_chroma(cfg_dc_chroma),
    .cfg_ac_luma(cfg_ac_luma), .cfg_ac_chroma(cfg_ac_chroma), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .blk_idx(blk_idx), .coef_idx(coef_idx),
    .blk_is_luma(blk_is_luma), .dc_base(dc_base), .ac_base(ac_base));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_run(input logic [2:0] n, input logic [5:0] lv, input logic [31:0] src,
                        input logic [15:0] dl, input logic [15:0] dc,
                        input logic [15:0] al, input logic [15:0] ac);
    int nexp;
    nexp = (n > 3'd6) ? 6 : int'(n);
    @(negedge clk);
    cfg_nblk = n; cfg_luma = lv; cfg_src_base = src;
    cfg_dc_luma = dl; cfg_dc_chroma = dc; cfg_ac_luma = al; cfg_ac_chroma = ac;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble setup after capture
    cfg_nblk = 3'd1; cfg_luma = ~lv; cfg_src_base = src ^ 32'h0F0F_0000;
    cfg_dc_luma = ~dl; cfg_dc_chroma = ~dc; cfg_ac_luma = ~al; cfg_ac_chroma = ~ac;
    if (nexp == 0) begin
      check(done && !busy && !rd_valid, "R4", "zero-block done/busy/valid",
            {61'b0, done, busy, rd_valid}, 64'b100);
    end
    for (int k = 0; k < nexp * 64; k++) begin
      int b, c;
      bit lum;
      logic [31:0] ea;
      logic [15:0] ed, eac;
      b = k / 64; c = k % 64;
      lum = lv[b];
      ea = src + 32'(2 * k);
      ed = (lum ? dl : dc) & 16'hFFFC;
      eac = (lum ? al : ac) & 16'hFFFC;
      check(busy && rd_valid && !done, "R1", "busy/valid during run",
            {61'b0, busy, rd_valid, done}, 64'b110);
      check(rd_addr == ea, "R2", "read address", rd_addr, ea);
      check(blk_idx == 3'(b) && coef_idx == 6'(c), "R7", "block/coef index",
            {blk_idx, coef_idx}, {3'(b), 6'(c)});
      check(blk_is_luma == lum && dc_base == ed && ac_base == eac, "R5", "luma flag and bases",
            {blk_is_luma, dc_base, ac_base}, {lum, ed, eac});
      check(dc_base[1:0] == 2'b00 && ac_base[1:0] == 2'b00, "R6", "base alignment",
            {dc_base, ac_base}, {ed, eac});
      if (k == 5) start = 1'b1;  // R8: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    if (nexp > 0) begin
      check(done && !busy && !rd_valid, "R10", "done after last read",
            {61'b0, done, busy, rd_valid}, 64'b100);
      if (n == 3'd7)
        check(done, "R3", "clamp to 6 blocks ends run after 384 reads", 64'(done), 64'b1);
      check(blk_idx != 3'd7, "R8", "no restart from mid-run start", 64'(blk_idx), 64'(nexp));
    end
    @(negedge clk);
    check(!done && !busy, "R10", "done is single cycle", {62'b0, done, busy}, 64'b0);
  endtask

  initial begin
    logic [5:0] masks [4];
    masks[0] = 6'b000000; masks[1] = 6'b111111; masks[2] = 6'b101001; masks[3] = 6'b010110;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_valid, "R1", "reset state idle",
          {61'b0, busy, done, rd_valid}, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 8; n++)
      for (int m = 0; m < 4; m++)
        do_run(3'(n), masks[m], 32'h1000_0000 + 32'(n * 4096 + m * 256),
               16'h1233 + 16'(m), 16'h2345, 16'h3457 + 16'(n), 16'h4562);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule